// File: doc/BRIEF.md
# Status Packet Byte Serializer

This block keeps a parallel status vector and, when asked, sends it as a short byte-serial packet on an 8-bit output. When it has something to send it raises a request and places the register address byte on the output. The downstream consumer answers with a one-cycle start pulse, which accepts that address byte. The remaining bytes then follow, one per clock with no gaps. The payload begins with a byte that packs a 6-bit sequence number with the two lowest status bits, continues with 8-bit slices of the rest of the status, and ends with optional extra 32-bit words. Each extra word carries its own address byte.

An 8-bit control word sets the sequence number and one of three modes. Off sends nothing. Send-once raises a single request when the word is written. Automatic raises a request whenever the status vector changes. All bytes of a packet come from a snapshot taken when start is accepted. An optional input register, chosen by a parameter, retimes the status vector before change detection and capture.

Top module: `stat_pkt_tx`

## Requirements
- R1: After synchronous reset, `req` is 0, `ad_out` is 0x00 and the mode is off.
- R2: A control write with bits 7:6 = 01 (send once) sets `req` on the next cycle. While `req` is high and no packet is in flight, `ad_out` shows the address byte `REG_ADDR`.
- R3: When `start` is sampled high while `req` is high, `req` is low from the next cycle. The payload bytes then appear on `ad_out` in the consecutive cycles that follow, with no gaps. After the last byte, `ad_out` returns to 0x00.
- R4: Payload byte 1 is {seq[5:0], status[1:0]}, where seq is control bits 5:0.
- R5: Payload bytes 2, 3 and 4 are status[9:2], status[17:10] and status[25:18]. Any bits beyond the status width are zero.
- R6: After the status bytes, each extra word k (k = 0 first) is sent as the byte `REG_ADDR+1+k`, followed by its four data bytes, least significant byte first.
- R7: In automatic mode (bits 7:6 = 10), a change of the status vector raises `req`. Writing automatic mode alone, or holding the status steady, raises nothing.
- R8: In automatic mode, a status change seen while a packet is in flight raises `req` in the cycle right after the last byte of that packet.
- R9: In off mode (00) and in the reserved mode (11), status changes raise no request. Writing either of these modes drops a pending `req` on the next cycle.
- R10: Status changes after `start` is accepted do not alter the bytes of the packet in flight.
- R11: With `REGISTER_INPUT` = 1, a status change reaches change detection one cycle later, so `req` rises two cycles after the change is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| status_in | input | STATUS_W | Parallel status vector |
| extra_in | input | EXTRA_WORDS*32 | Extra words; word k is bits 32k+31:32k |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wd | input | 8 | Control word: 7:6 mode, 5:0 sequence number |
| start | input | 1 | Acknowledge of the address byte |
| ad_out | output | 8 | Serial address/data byte |
| req | output | 1 | Request to send a packet |

## Verification
If the byte counter is off by one, the result shows at the ports within one packet. It appears as a repeated or missing byte, or as a nonzero `ad_out` in the cycle after the expected last byte. A stale pending flag shows as a request in the cycle after a packet ends even though the status did not change. A lost pending flag shows as no request at that point. If the snapshot is taken at the wrong time, the packet sent during the mid-packet status change carries the new slices instead of the old ones. If the input register is missing, `req` rises one cycle early.

// File: rtl/stat_pkt_pkg.sv
package stat_pkt_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_ONCE = 2'd1,
      MODE_AUTO = 2'd2,
      MODE_RSVD = 2'd3
   } sp_mode_e;

   localparam int SEQ_W = 6;

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/stat_pkt_in_stage.sv
module stat_pkt_in_stage #(
   parameter int W              = 26,
   parameter bit REGISTER_INPUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         changed
);
   logic [W-1:0] cur;
   logic [W-1:0] seen;

   generate
      if (REGISTER_INPUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) cur <= '0;
            else     cur <= din;
         end
      end else begin : g_comb
         assign cur = din;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) seen <= '0;
      else     seen <= cur;
   end

   assign dout    = cur;
   assign changed = (cur != seen);
endmodule

// File: rtl/stat_pkt_ctrl.sv
module stat_pkt_ctrl
   import stat_pkt_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             ctrl_we,
   input  logic [7:0]       ctrl_wd,
   input  logic             changed,
   input  logic             start,
   input  logic             ser_busy,
   input  logic             ser_last,
   output logic             req,
   output logic             load,
   output logic [SEQ_W-1:0] seq
);
   sp_mode_e         mode_q;
   sp_mode_e         wr_mode;
   logic [SEQ_W-1:0] seq_q;
   logic             req_q, pend_q;
   logic             once_wr, off_wr, trig, free, req_set;

   assign wr_mode = sp_mode_e'(ctrl_wd[7:6]);
   assign once_wr = ctrl_we && (wr_mode == MODE_ONCE);
   assign off_wr  = ctrl_we && ((wr_mode == MODE_OFF) || (wr_mode == MODE_RSVD));
   assign trig    = once_wr || ((mode_q == MODE_AUTO) && changed);
   assign free    = !ser_busy || ser_last;
   assign load    = req_q && start;
   assign req_set = !load && !off_wr && free && (trig || pend_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_OFF;
         seq_q  <= '0;
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (ctrl_we) begin
            mode_q <= wr_mode;
            seq_q  <= ctrl_wd[SEQ_W-1:0];
         end
         if (load || off_wr) req_q <= 1'b0;
         else if (req_set)   req_q <= 1'b1;
         if (off_wr || req_set)  pend_q <= 1'b0;
         else if (trig && !free) pend_q <= 1'b1;
      end
   end

   assign req = req_q;
   assign seq = seq_q;

   assert_req_drops_R3: assert property (@(posedge clk) disable iff (rst)
      (req_q && start) |=> !req_q);
   assert_off_cancels_R9: assert property (@(posedge clk) disable iff (rst)
      off_wr |=> !req_q);
   assert_no_req_in_packet_R3: assert property (@(posedge clk) disable iff (rst)
      (ser_busy && !ser_last) |-> !req_q);
   assert_once_raises_R2: assert property (@(posedge clk) disable iff (rst)
      (once_wr && !ser_busy && !load) |=> req_q);
endmodule

// File: rtl/stat_pkt_ser.sv
module stat_pkt_ser
   import stat_pkt_pkg::*;
#(
   parameter int          STATUS_W    = 26,
   parameter int          EXTRA_WORDS = 2,
   parameter logic [7:0]  REG_ADDR    = 8'h34,
   localparam int         EXW         = (EXTRA_WORDS > 0) ? EXTRA_WORDS * 32 : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [SEQ_W-1:0]    seq,
   input  logic [STATUS_W-1:0] stat,
   input  logic [EXW-1:0]      extra,
   output logic                busy,
   output logic                last,
   output logic [7:0]          byte_out
);
   localparam int STAT_BYTES = ceil_div(STATUS_W - 2, 8);
   localparam int PAY_BYTES  = 1 + STAT_BYTES + 5 * EXTRA_WORDS;
   localparam int CNT_W      = $clog2(PAY_BYTES + 1);

   logic [PAY_BYTES*8-1:0]  pay;
   logic [PAY_BYTES*8-1:0]  sh;
   logic [STAT_BYTES*8-1:0] slice_pad;
   logic [CNT_W-1:0]        cnt;

   always_comb begin
      slice_pad = '0;
      slice_pad[STATUS_W-3:0] = stat[STATUS_W-1:2];
   end

   assign pay[7:0]                = {seq, stat[1:0]};
   assign pay[8 +: STAT_BYTES*8]  = slice_pad;

   generate
      for (genvar k = 0; k < EXTRA_WORDS; k++) begin : g_extra
         localparam logic [7:0] WADDR = 8'(REG_ADDR + 1 + k);
         assign pay[(1 + STAT_BYTES + 5*k)*8 +: 40] = {extra[k*32 +: 32], WADDR};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         sh  <= '0;
      end else if (load) begin
         cnt <= CNT_W'(PAY_BYTES);
         sh  <= pay;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
         sh  <= sh >> 8;
      end
   end

   assign busy     = (cnt != '0);
   assign last     = (cnt == CNT_W'(1));
   assign byte_out = sh[7:0];

   assert_first_payload_R4: assert property (@(posedge clk) disable iff (rst)
      load |=> (busy && byte_out == {$past(seq), $past(stat[1:0])}));
   assert_packet_ends_R3: assert property (@(posedge clk) disable iff (rst)
      (last && !load) |=> !busy);
endmodule

// File: rtl/stat_pkt_tx.sv
module stat_pkt_tx
   import stat_pkt_pkg::*;
#(
   parameter int         STATUS_W       = 26,
   parameter int         EXTRA_WORDS    = 2,
   parameter logic [7:0] REG_ADDR       = 8'h34,
   parameter bit         REGISTER_INPUT = 1'b1
) (
   input  logic                                            clk,
   input  logic                                            rst,
   input  logic [STATUS_W-1:0]                             status_in,
   input  logic [((EXTRA_WORDS > 0) ? EXTRA_WORDS*32 : 1)-1:0] extra_in,
   input  logic                                            ctrl_we,
   input  logic [7:0]                                      ctrl_wd,
   input  logic                                            start,
   output logic [7:0]                                      ad_out,
   output logic                                            req
);
   generate
      if (STATUS_W < 3) begin : g_bad_width
         $error("stat_pkt_tx: STATUS_W must be at least 3");
      end
      if (EXTRA_WORDS < 0 || int'(REG_ADDR) + EXTRA_WORDS > 255) begin : g_bad_extra
         $error("stat_pkt_tx: extra word addresses exceed 8 bits");
      end
   endgenerate

   logic [STATUS_W-1:0] stat_cur;
   logic                changed, load, busy, last;
   logic [SEQ_W-1:0]    seq;
   logic [7:0]          ser_byte;

   stat_pkt_in_stage #(.W(STATUS_W), .REGISTER_INPUT(REGISTER_INPUT)) i_in (
      .clk(clk), .rst(rst), .din(status_in), .dout(stat_cur), .changed(changed));

   stat_pkt_ctrl i_ctrl (
      .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
      .changed(changed), .start(start), .ser_busy(busy), .ser_last(last),
      .req(req), .load(load), .seq(seq));

   stat_pkt_ser #(.STATUS_W(STATUS_W), .EXTRA_WORDS(EXTRA_WORDS), .REG_ADDR(REG_ADDR)) i_ser (
      .clk(clk), .rst(rst), .load(load), .seq(seq), .stat(stat_cur),
      .extra(extra_in), .busy(busy), .last(last), .byte_out(ser_byte));

   assign ad_out = busy ? ser_byte : (req ? REG_ADDR : 8'h00);

   assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (busy && !last) |=> (busy || ad_out == 8'h00 || req));
   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
      busy |-> !(req && ad_out == REG_ADDR && !last && start));
endmodule

// File: tb/test_stat_pkt_tx.sv
module test_stat_pkt_tx;
   localparam int         SW   = 26;
   localparam int         EW   = 2;
   localparam logic [7:0] ADDR = 8'h34;
   localparam int         PAY  = 1 + 3 + 5 * EW;
   localparam int         NVEC = 4;

   localparam logic [5:0]  T_SEQ [NVEC] = '{6'd1, 6'h2A, 6'h3F, 6'd0};
   localparam logic [25:0] T_ST  [NVEC] = '{26'h3FF_FFFF, 26'h123_4567, 26'h000_0002, 26'h2AA_AAA9};
   localparam logic [63:0] T_EX  [NVEC] = '{64'h1122_3344_5566_7788, 64'h0, 64'hFFFF_FFFF_0000_0001, 64'hDEAD_BEEF_CAFE_F00D};

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [SW-1:0]  status_in = '0;
   logic [EW*32-1:0] extra_in = '0;
   logic           ctrl_we = 1'b0;
   logic [7:0]     ctrl_wd = '0;
   logic           start = 1'b0;
   logic [7:0]     ad_out;
   logic           req;
   int             checks = 0, fails = 0;
   bit             done = 1'b0;

   always #10 clk = ~clk;

   stat_pkt_tx #(.STATUS_W(SW), .EXTRA_WORDS(EW), .REG_ADDR(ADDR), .REGISTER_INPUT(1'b1)) i_stat_pkt_tx (
      .clk(clk), .rst(rst), .status_in(status_in), .extra_in(extra_in),
      .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd), .start(start), .ad_out(ad_out), .req(req));

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int i, input logic [5:0] sq,
                                           input logic [25:0] st, input logic [63:0] ex);
      int j, w, p;
      if (i == 0) return ADDR;
      if (i == 1) return {sq, st[1:0]};
      if (i <= 4) return 8'(st >> (2 + 8 * (i - 2)));
      j = i - 5; w = j / 5; p = j % 5;
      if (p == 0) return 8'(ADDR + 1 + w);
      return 8'(ex >> (w * 32 + (p - 1) * 8));
   endfunction

   task automatic write_ctrl(input logic [1:0] md, input logic [5:0] sq);
      ctrl_we = 1'b1; ctrl_wd = {md, sq};
      tick();
      ctrl_we = 1'b0;
   endtask

   // Caller is at a negedge with req high; leaves at the negedge of the last byte.
   task automatic recv(input string tag, input logic [5:0] sq, input logic [25:0] st,
                       input logic [63:0] ex, input bit scramble);
      check({tag, " R2 addr byte"}, ad_out, exp_byte(0, sq, st, ex));
      start = 1'b1;
      for (int i = 1; i <= PAY; i++) begin
         tick();
         if (i == 1) begin
            start = 1'b0;
            check({tag, " R3 req drops"}, req, 0);
         end
         if (i == 2 && scramble) status_in = ~st;
         check($sformatf("%s R4 R5 R6 R10 byte %0d", tag, i), ad_out, exp_byte(i, sq, st, ex));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      tick();
      check("R1 reset req", req, 0);
      check("R1 reset ad_out", ad_out, 0);

      // Table walk: send-once packets with varied fields
      for (int v = 0; v < NVEC; v++) begin
         status_in = T_ST[v]; extra_in = T_EX[v];
         tick(); tick();
         check("R1 R9 no request while idle", req, 0);
         write_ctrl(2'b01, T_SEQ[v]);
         check("R2 once raises req", req, 1);
         recv("vec", T_SEQ[v], T_ST[v], T_EX[v], 1'b0);
         tick();
         check("R3 ad_out idle after packet", ad_out, 0);
         check("R3 no req after packet", req, 0);
      end

      // Automatic mode
      write_ctrl(2'b10, 6'd9);
      check("R7 auto write alone", req, 0);
      tick(); tick();
      check("R7 steady status", req, 0);
      status_in = 26'h0AB_CDE1;
      tick();
      check("R11 registered input delay", req, 0);
      tick();
      check("R7 change raises req", req, 1);
      recv("auto", 6'd9, 26'h0AB_CDE1, T_EX[NVEC-1], 1'b1);
      tick();
      check("R8 req right after packet", req, 1);
      check("R8 addr byte after packet", ad_out, ADDR);
      recv("auto2", 6'd9, ~26'h0AB_CDE1, T_EX[NVEC-1], 1'b0);
      tick();
      check("R8 no extra req", req, 0);
      check("R3 idle after second packet", ad_out, 0);

      // Off and reserved modes
      write_ctrl(2'b00, 6'd0);
      status_in = 26'h155_5555;
      repeat (3) tick();
      check("R9 off ignores change", req, 0);
      write_ctrl(2'b11, 6'd0);
      status_in = 26'h0F0_F0F0;
      repeat (3) tick();
      check("R9 reserved ignores change", req, 0);
      check("R9 reserved ad_out", ad_out, 0);

      // Cancel a pending request
      write_ctrl(2'b01, 6'd3);
      check("R2 once again", req, 1);
      write_ctrl(2'b00, 6'd3);
      check("R9 off cancels req", req, 0);
      check("R9 off cancel ad_out", ad_out, 0);

      // Reset while requesting
      write_ctrl(2'b01, 6'd4);
      check("R2 req before reset", req, 1);
      rst = 1'b1;
      tick();
      rst = 1'b0;
      check("R1 reset clears req", req, 0);
      check("R1 reset clears ad_out", ad_out, 0);
      status_in = 26'h3C3_C3C3;
      repeat (3) tick();
      check("R1 mode off after reset", req, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule